// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces a repeated-start condition on an open-drain I2C bus for a master that has just finished a transfer. Software writes a request bit. If the master is idle and no other bus event is running, the sequencer steps through four phases, each one baud period long:

1. Hold SCL low.
2. Let SDA float high.
3. Let SCL float high, waiting for it to be seen high.
4. Pull SDA low while SCL stays high.

It then clears the request, raises an interrupt flag and keeps SDA pulled low, ready for the first address bit.

A down-counter sets the timing. It is loaded from a reload input each time a phase begins. Phases that follow a released line begin only when the synchronized line is actually seen at the expected level. A slave that stretches SCL therefore delays the rest of the sequence instead of shortening it. Two bus-collision rules abort the sequence. Writes made while the sequence is running are refused: transmit-buffer writes set a write-collision flag, and request writes are ignored. A separate detector watches the synchronized lines and reports a start condition.

Top module: `i2c_rstart_seq`

## Requirements
- R1: After reset both pull outputs are low, the request bit, all flags, the start-seen bit and the transmit buffer are zero. A request write (req_wr with req_wdata=1) is accepted only when no sequence is running and other_busy is low; otherwise it has no effect.
- R2: On the accepting clock edge (edge 0) scl_pull goes high and req_q becomes 1. The line inputs pass two synchronizer flops, so SCL pulled low at edge 0 is seen at edge 3. At edge 3 SDA is released and the counter is loaded. If SDA was held from an earlier sequence, sda_pull falls at edge 3.
- R3: The baud period for reload value N is N clock cycles, and a reload of 0 gives a period of one cycle.
- R4: scl_pull falls only when the SDA-high period has expired and synchronized SDA is high. With period P and SDA already high this is edge 3+P. When SDA was held before the sequence, it is edge max(3+P, 6).
- R5: The counter is reloaded for the both-high period only once synchronized SCL is seen high, three edges after SCL actually rises. Clock stretching delays all later events by the stretch length.
- R6: After the both-high period, sda_pull goes high for one period with SCL released. At its end req_q clears, irq_flag sets, scl_pull stays low and sda_pull stays high. Without stretching, with SCL released at edge T: sda_pull rises at T+3+P and irq_flag at T+3+2P.
- R7: start_seen sets when synchronized SDA falls while synchronized SCL is high. It clears when a request is accepted.
- R8: If synchronized SDA is low when synchronized SCL is first seen high after release, the sequence aborts. Both pulls are released, req_q clears and bcol_flag sets, at edge T+3.
- R9: If synchronized SCL goes low during the both-high period, the sequence aborts the same way as in R8.
- R10: A transmit-buffer write while a sequence runs sets wcol_flag and leaves txbuf_q unchanged. While idle, the write loads txbuf_q and leaves wcol_flag unchanged.
- R11: Request writes of any value during a running sequence are ignored; req_q stays 1.
- R12: flag_clr is write-one-to-clear: bit 0 clears irq_flag, bit 1 clears bcol_flag and bit 2 clears wcol_flag, each independently. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| other_busy | input | 1 | Another bus event of the master is in progress |
| req_wr | input | 1 | Write strobe for the request bit |
| req_wdata | input | 1 | Value written to the request bit |
| flag_clr | input | 3 | Write-one-to-clear for irq, bus-collision and write-collision flags |
| txbuf_wr | input | 1 | Transmit-buffer write strobe |
| txbuf_wdata | input | DW | Transmit-buffer write data |
| brg_reload | input | BRG_W | Baud counter reload value |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| sda_pull | output | 1 | Pull SDA low when high |
| scl_pull | output | 1 | Pull SCL low when high |
| req_q | output | 1 | Request bit readback |
| start_seen | output | 1 | Start condition observed on the lines |
| irq_flag | output | 1 | Sequence-complete interrupt flag |
| bcol_flag | output | 1 | Bus-collision flag |
| wcol_flag | output | 1 | Write-collision flag |
| txbuf_q | output | DW | Transmit buffer contents |

## Verification
The bench aims at three kinds of timing fault:
- A SCL release that ignores a still-low SDA. When SDA is handed over from an earlier sequence with a one-cycle period, a wrong design releases SCL at edge 4 instead of edge 6.
- A both-high period started on the release edge rather than on the observed level. Under a stretched clock this shortens the start setup, and every later event lands early.
- A reload of zero taken literally. The counter would wrap and stretch each phase to its full range.

Both collision rules are driven from the line model. A design that checks SCL only at the rising moment, or that keeps SDA pulled after an abort, shows up through misplaced or extra pull edges. Writes made mid-sequence check that the buffer and request bit are frozen and not merely flagged.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_SCL_LO,
    RS_SDA_HI,
    RS_SCL_REL,
    RS_BOTH_HI,
    RS_SDA_LO
  } rs_state_e;

  localparam int CLR_IRQ  = 0;
  localparam int CLR_BCOL = 1;
  localparam int CLR_WCOL = 2;

  // Cycles in one baud period for a given reload value; zero maps to one.
  function automatic int unsigned brg_cycles(input int unsigned reload);
    return (reload == 0) ? 32'd1 : reload;
  endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/i2c_rs_baud.sv
module i2c_rs_baud import i2c_rs_pkg::*; #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  output logic         tmo_o,
  output logic         run_o
);

  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load_i) begin
      cnt <= W'(brg_cycles(32'(reload_i)) - 32'd1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign tmo_o = run && (cnt == '0);
  assign run_o = run;

  // R3: a zero reload expires in the very next cycle
  a_r3_zero_reload_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && reload_i == '0) |=> tmo_o);

  // R3: a running count does not stop before it expires
  a_r3_run_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !tmo_o && !load_i) |=> run_o);

endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq import i2c_rs_pkg::*; #(
  parameter int BRG_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             other_busy,
  input  logic             req_wr,
  input  logic             req_wdata,
  input  logic [2:0]       flag_clr,
  input  logic             txbuf_wr,
  input  logic [DW-1:0]    txbuf_wdata,
  input  logic [BRG_W-1:0] brg_reload,
  input  logic             sda_in,
  input  logic             scl_in,
  output logic             sda_pull,
  output logic             scl_pull,
  output logic             req_q,
  output logic             start_seen,
  output logic             irq_flag,
  output logic             bcol_flag,
  output logic             wcol_flag,
  output logic [DW-1:0]    txbuf_q
);

  // ---------------- line synchronizer ----------------
  logic [1:0] line_s;
  i2c_rs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_in, sda_in}),
    .q_o   (line_s)
  );
  logic sda_s, scl_s, sda_s_d;
  assign sda_s = line_s[0];
  assign scl_s = line_s[1];

  // ---------------- baud counter ----------------
  logic brg_load, brg_tmo, brg_run, brg_done;
  i2c_rs_baud #(.W(BRG_W)) u_brg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (brg_load),
    .reload_i (brg_reload),
    .tmo_o    (brg_tmo),
    .run_o    (brg_run)
  );
  assign brg_done = brg_tmo || !brg_run;

  // ---------------- named events ----------------
  rs_state_e st, st_nx;
  logic seq_busy, req_accept, col_sda, col_scl, bus_col, seq_finish, start_evt, wcol_evt;
  logic sda_hold;

  assign seq_busy   = (st != RS_IDLE);
  assign req_accept = req_wr && req_wdata && !seq_busy && !other_busy;
  assign col_sda    = (st == RS_SCL_REL) && scl_s && !sda_s;
  assign col_scl    = (st == RS_BOTH_HI) && !scl_s;
  assign bus_col    = col_sda || col_scl;
  assign seq_finish = (st == RS_SDA_LO) && brg_tmo;
  assign start_evt  = sda_s_d && !sda_s && scl_s;
  assign wcol_evt   = txbuf_wr && seq_busy;

  // ---------------- sequence state machine ----------------
  always_comb begin
    st_nx    = st;
    brg_load = 1'b0;
    unique case (st)
      RS_IDLE:    if (req_accept) st_nx = RS_SCL_LO;
      RS_SCL_LO:  if (!scl_s) begin
                    st_nx    = RS_SDA_HI;
                    brg_load = 1'b1;
                  end
      RS_SDA_HI:  if (brg_done && sda_s) st_nx = RS_SCL_REL;
      RS_SCL_REL: if (col_sda) st_nx = RS_IDLE;
                  else if (scl_s) begin
                    st_nx    = RS_BOTH_HI;
                    brg_load = 1'b1;
                  end
      RS_BOTH_HI: if (col_scl) st_nx = RS_IDLE;
                  else if (brg_tmo) begin
                    st_nx    = RS_SDA_LO;
                    brg_load = 1'b1;
                  end
      RS_SDA_LO:  if (brg_tmo) st_nx = RS_IDLE;
      default:    st_nx = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RS_IDLE;
      sda_hold <= 1'b0;
      sda_s_d  <= 1'b1;
    end else begin
      st      <= st_nx;
      sda_s_d <= sda_s;
      if (seq_finish)                     sda_hold <= 1'b1;
      else if (st == RS_SCL_LO && !scl_s) sda_hold <= 1'b0;
    end
  end

  assign scl_pull = (st == RS_SCL_LO) || (st == RS_SDA_HI);
  assign sda_pull = (st == RS_SDA_LO) ||
                    (sda_hold && (st == RS_IDLE || st == RS_SCL_LO));

  // ---------------- control and status ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      start_seen <= 1'b0;
      irq_flag   <= 1'b0;
      bcol_flag  <= 1'b0;
      wcol_flag  <= 1'b0;
      txbuf_q    <= '0;
    end else begin
      if (req_accept)                 req_q <= 1'b1;
      else if (seq_finish || bus_col) req_q <= 1'b0;

      if (start_evt)       start_seen <= 1'b1;
      else if (req_accept) start_seen <= 1'b0;

      if (seq_finish)              irq_flag <= 1'b1;
      else if (flag_clr[CLR_IRQ])  irq_flag <= 1'b0;

      if (bus_col)                 bcol_flag <= 1'b1;
      else if (flag_clr[CLR_BCOL]) bcol_flag <= 1'b0;

      if (wcol_evt)                wcol_flag <= 1'b1;
      else if (flag_clr[CLR_WCOL]) wcol_flag <= 1'b0;

      if (txbuf_wr && !seq_busy) txbuf_q <= txbuf_wdata;
    end
  end

  // ---------------- assertions ----------------
  a_r1_ignored_when_other_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && other_busy) |=> !seq_busy);

  a_r4_scl_release_needs_sda: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> $past(sda_s));

  a_r5_no_count_while_scl_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_SCL_REL) |-> !brg_run);

  a_r6_irq_after_sda_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(sda_pull) && sda_pull && !scl_pull && !req_q));

  a_r7_start_with_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_seen) |-> $past(scl_s));

  a_r8_collision_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol_flag) |-> (!scl_pull && !sda_pull && !req_q));

  a_r10_wcol_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_wr && seq_busy) |=> (wcol_flag && $stable(txbuf_q)));

  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> req_q);

endmodule

// File: tb/i2c_rstart_seq_bench.sv
`timescale 1ns/1ps
module i2c_rstart_seq_bench;

  localparam int BRG_W = 7;
  localparam int DW    = 8;
  localparam int K_SCL_ON = 0, K_SCL_OFF = 1, K_SDA_ON = 2, K_SDA_OFF = 3, K_IRQ = 4, K_BCOL = 5;

  logic clk = 0, rst_n = 0;
  logic other_busy = 0, req_wr = 0, req_wdata = 0, txbuf_wr = 0;
  logic [2:0] flag_clr = '0;
  logic [DW-1:0] txbuf_wdata = '0;
  logic [BRG_W-1:0] brg_reload = '0;
  logic sda_in, scl_in, sda_pull, scl_pull, req_q, start_seen, irq_flag, bcol_flag, wcol_flag;
  logic [DW-1:0] txbuf_q;

  logic tb_sda_low = 0, tb_scl_force = 0, stretch_seen = 0;
  int stretch_cnt = 0;
  int cyc = 0, seq_start = 0, n_cmp = 0, n_bad = 0;
  bit mon_on = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  // open-drain line model with a clock-stretching slave
  assign sda_in = !(sda_pull || tb_sda_low);
  assign scl_in = !(scl_pull || tb_scl_force || (stretch_seen && stretch_cnt != 0));

  always @(negedge clk) begin
    if (scl_pull) stretch_seen = 1;
    else if (stretch_seen && stretch_cnt > 0) stretch_cnt--;
  end

  i2c_rstart_seq #(.BRG_W(BRG_W), .DW(DW)) u_i2c_rstart_seq (
    .clk, .rst_n, .other_busy, .req_wr, .req_wdata, .flag_clr, .txbuf_wr, .txbuf_wdata,
    .brg_reload, .sda_in, .scl_in, .sda_pull, .scl_pull, .req_q, .start_seen,
    .irq_flag, .bcol_flag, .wcol_flag, .txbuf_q
  );

  // ---------------- scoreboard ----------------
  typedef struct { int kind; int at; string req; } ev_t;
  ev_t expq[$];

  task automatic push(input int k, input int at, input string rq);
    ev_t e;
    e.kind = k; e.at = at; e.req = rq;
    expq.push_back(e);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic obs(input int k);
    ev_t e;
    int d;
    d = cyc - seq_start;
    n_cmp++;
    if (expq.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual kind %0d at %0d expected none", k, d);
    end else begin
      e = expq.pop_front();
      if (e.kind != k || e.at != d) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d at %0d expected kind %0d at %0d", e.req, k, d, e.kind, e.at);
      end
    end
  endtask

  logic p_scl = 0, p_sda = 0, p_irq = 0, p_bcol = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (scl_pull != p_scl) obs(scl_pull ? K_SCL_ON : K_SCL_OFF);
      if (sda_pull != p_sda) obs(sda_pull ? K_SDA_ON : K_SDA_OFF);
      if (irq_flag && !p_irq) obs(K_IRQ);
      if (bcol_flag && !p_bcol) obs(K_BCOL);
    end
    p_scl = scl_pull; p_sda = sda_pull; p_irq = irq_flag; p_bcol = bcol_flag;
  end

  task automatic wait_delta(input int d);
    while (cyc - seq_start < d) @(negedge clk);
  endtask

  // mode 0: complete, 1: SDA low at SCL rise, 2: SCL pulled low while both high
  task automatic run_seq(input int rl, input int xs, input bit held, input int mode,
                         input bit poke, input string tg);
    int p, e, trel, trise, tlast;
    p = (rl == 0) ? 1 : rl;
    e = (xs == 0) ? 0 : xs - 1;
    trel = 3 + p;
    if (held && trel < 6) trel = 6;
    trise = trel + 3 + e;
    @(negedge clk);
    brg_reload = BRG_W'(rl); flag_clr = 3'b111; stretch_cnt = xs; stretch_seen = 0;
    @(negedge clk);
    flag_clr = '0; req_wr = 1; req_wdata = 1; seq_start = cyc + 1;
    push(K_SCL_ON, 0, "R2");
    if (held) push(K_SDA_OFF, 3, "R2");
    push(K_SCL_OFF, trel, tg);
    if (mode == 0) begin
      push(K_SDA_ON, trise + p, "R6");
      push(K_IRQ, trise + 2 * p, tg);
      tlast = trise + 2 * p;
    end else if (mode == 1) begin
      push(K_BCOL, trel + 3, "R8");
      tlast = trel + 3;
    end else begin
      push(K_BCOL, trel + 6, "R9");
      tlast = trel + 6;
    end
    @(negedge clk);
    req_wr = 0; req_wdata = 0;
    chk("R2 req set", req_q, 1);
    chk("R7 cleared on accept", start_seen, 0);
    if (poke) begin
      wait_delta(2);
      req_wr = 1; req_wdata = 0; txbuf_wr = 1; txbuf_wdata = 8'h3C;
      @(negedge clk);
      req_wr = 0; txbuf_wr = 0;
      chk("R11 request write ignored", req_q, 1);
      chk("R10 wcol set", wcol_flag, 1);
      chk("R10 buffer unchanged", txbuf_q, 8'hA5);
    end
    if (mode == 1) begin wait_delta(trel); tb_sda_low = 1; end
    if (mode == 2) begin wait_delta(trel + 3); tb_scl_force = 1; end
    wait_delta(tlast + 2);
    tb_sda_low = 0; tb_scl_force = 0;
    if (mode == 0) begin
      chk("R6 req cleared", req_q, 0);
      chk("R6 irq set", irq_flag, 1);
      chk("R6 SDA held low", sda_pull, 1);
      chk("R6 SCL released", scl_pull, 0);
      chk("R7 start seen", start_seen, 1);
    end else begin
      chk(mode == 1 ? "R8 req cleared" : "R9 req cleared", req_q, 0);
      chk(mode == 1 ? "R8 SDA released" : "R9 SDA released", sda_pull, 0);
      chk(mode == 1 ? "R8 SCL released" : "R9 SCL released", scl_pull, 0);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    while (expq.size() != 0) begin
      ev_t e;
      e = expq.pop_front();
      n_cmp++; n_bad++;
      $display("FAIL %s: actual missing expected kind %0d at %0d", e.req, e.kind, e.at);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 req_q", req_q, 0);
    chk("R1 flags", {irq_flag, bcol_flag, wcol_flag, start_seen}, 0);
    chk("R1 txbuf", txbuf_q, 0);
    mon_on = 1;

    // R1: request while another event runs is ignored
    other_busy = 1; req_wr = 1; req_wdata = 1;
    @(negedge clk);
    req_wr = 0; req_wdata = 0;
    repeat (4) @(negedge clk);
    other_busy = 0;
    chk("R1 busy request ignored", req_q, 0);
    chk("R1 busy no SCL pull", scl_pull, 0);

    // R10: idle buffer write loads
    txbuf_wr = 1; txbuf_wdata = 8'hA5;
    @(negedge clk);
    txbuf_wr = 0;
    chk("R10 idle buffer load", txbuf_q, 8'hA5);
    chk("R10 idle no wcol", wcol_flag, 0);

    run_seq(5, 0, 0, 0, 1, "R4");   // nominal, with mid-sequence writes
    // R12: independent clears
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = '0;
    chk("R12 irq cleared", irq_flag, 0);
    chk("R12 wcol kept", wcol_flag, 1);
    flag_clr = 3'b100;
    @(negedge clk);
    flag_clr = '0;
    chk("R12 wcol cleared", wcol_flag, 0);

    run_seq(0, 0, 1, 0, 0, "R3");   // zero reload, SDA handed over low
    run_seq(4, 4, 1, 0, 0, "R5");   // stretched SCL
    run_seq(5, 0, 1, 1, 0, "R4");   // SDA low at SCL rise
    chk("R8 bcol set", bcol_flag, 1);
    flag_clr = 3'b010;
    @(negedge clk);
    flag_clr = '0;
    chk("R12 bcol cleared", bcol_flag, 0);
    run_seq(6, 0, 0, 2, 0, "R4");   // SCL lost during both-high period
    chk("R9 bcol set", bcol_flag, 1);
    run_seq(3, 0, 0, 0, 0, "R3");
    finish_run();
  end

endmodule